// File: doc/BRIEF.md
# Stereo Serial Audio Deserializer

This block turns a three-wire stereo audio stream into parallel samples. The stream has a word clock, a bit clock and one data line. Everything runs on one fast system clock. The block synchronizes the three serial inputs to that clock and finds the bit-clock falling edges and the word-clock rising edges digitally. It then counts bits inside each sample period and shifts the two's complement data, most significant bit first, into a left word and a right word. After the last right-channel bit is in, it presents both words together with a one-cycle valid strobe.

A frame starts at a word-clock rising edge, and the left slot starts with it. The right slot starts after a fixed half-frame bit count. The word-clock falling edge is never used, so a narrow pulse works as a word clock as well as a square wave does. A format input selects 32-bit slots (64 bit clocks per frame) or 24-bit slots (48 bit clocks per frame). The block latches this input at each frame start. When a frame ends early, the block drops the partial frame and flags an error.

Top module: `stereo_rx_deser`

## Requirements
- R1: While reset is held, and after it is released, `left_o` and `right_o` read zero and `valid_o` and `frame_err_o` read low.
- R2: Data is taken on bit-clock falling edges. The first half of the frame's bits, counted from a word-clock rising edge, form the left word and the second half form the right word. Each slot arrives most significant bit first.
- R3: With `fmt24` = 0, each slot is 32 bits and a frame is 64 bits. The first `OUT_W` bits of each slot make up the output word, and the rest of the slot is discarded.
- R4: With `fmt24` = 1, each slot is 24 bits and a frame is 48 bits. When `OUT_W` exceeds 24, the 24-bit word is sign-extended from its bit 23.
- R5: `fmt24` is sampled at each detected word-clock rising edge. A change of `fmt24` in the middle of a frame has no effect on that frame.
- R6: The word-clock falling edge has no effect. Any high width from one bit clock up to one bit clock short of the frame decodes the same way.
- R7: `valid_o` pulses for exactly one cycle, 3 system cycles after the bit-clock falling edge that carries the last bit of the right slot reaches the pin. `left_o` and `right_o` update in that cycle only and hold their values otherwise.
- R8: A word-clock rising edge that arrives before a full frame of bits has been taken raises `frame_err_o` for one cycle, 3 system cycles after the edge reaches the pin. That partial frame produces no strobe and leaves the outputs unchanged, and the next frame decodes normally.
- R9: Bit-clock falling edges beyond the frame length, before the next word-clock rising edge, are ignored and raise no error.
- R10: Bit-clock falling edges before the first word-clock rising edge after reset are ignored, and that first rising edge raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| wclk_in | input | 1 | Word clock; a rising edge starts a frame |
| sdata_in | input | 1 | Serial data, two's complement, MSB first |
| fmt24 | input | 1 | 0: 32-bit slots, 1: 24-bit slots |
| left_o | output | OUT_W | Left channel sample |
| right_o | output | OUT_W | Right channel sample |
| valid_o | output | 1 | One-cycle strobe when both samples update |
| frame_err_o | output | 1 | One-cycle flag for a short frame |

## Verification
The assertions assume the following about the inputs:
- Each bit-clock level lasts at least two system cycles, so the synchronizers never merge two edges.
- A word-clock rising edge never falls in the same system cycle as a bit-clock falling edge.
- `fmt24` is steady around the frame start.

The stimulus meets these assumptions. It holds each bit-clock level for four system cycles and changes every input half a system cycle away from the active edge. It raises the word clock together with a bit-clock rising edge, so word-clock edges always fall midway between bit-clock falls.

// File: rtl/stereo_rx_deser.sv
module stereo_rx_deser #(
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_in,
  input  logic             wclk_in,
  input  logic             sdata_in,
  input  logic             fmt24,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o,
  output logic             frame_err_o
);

  localparam int         K32 = (OUT_W < 32) ? OUT_W : 32;
  localparam int         K24 = (OUT_W < 24) ? OUT_W : 24;
  localparam logic [6:0] W7  = 7'(OUT_W);

  logic [2:0] bclk_p, wclk_p;
  logic [1:0] sd_p;
  logic       b_fall, w_rise, sd, active, fmt_q, capture;
  logic [6:0] cnt, half, flen, pos;
  logic [5:0] shamt;
  logic [OUT_W-1:0] sr, sr_nxt, ext, l_hold;
  logic signed [OUT_W-1:0] up;

  assign b_fall  = bclk_p[2] & ~bclk_p[1];
  assign w_rise  = wclk_p[1] & ~wclk_p[2];
  assign sd      = sd_p[1];
  assign half    = fmt_q ? 7'd24 : 7'd32;
  assign flen    = {half[5:0], 1'b0};
  assign pos     = (cnt < half) ? cnt : cnt - half;
  assign shamt   = fmt_q ? 6'(OUT_W - K24) : 6'(OUT_W - K32);
  assign capture = b_fall & active & (cnt != flen);

  always_comb begin
    if (pos == 7'd0)    sr_nxt = {{(OUT_W-1){1'b0}}, sd};
    else if (pos < W7)  sr_nxt = {sr[OUT_W-2:0], sd};
    else                sr_nxt = sr;
    up  = sr_nxt << shamt;
    ext = up >>> shamt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_p      <= '0;
      wclk_p      <= '0;
      sd_p        <= '0;
      active      <= 1'b0;
      fmt_q       <= 1'b0;
      cnt         <= '0;
      sr          <= '0;
      l_hold      <= '0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      bclk_p      <= {bclk_p[1:0], bclk_in};
      wclk_p      <= {wclk_p[1:0], wclk_in};
      sd_p        <= {sd_p[0], sdata_in};
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      if (w_rise) begin
        if (active && cnt != flen) frame_err_o <= 1'b1;
        active <= 1'b1;
        fmt_q  <= fmt24;
        cnt    <= '0;
      end else if (capture) begin
        cnt <= cnt + 7'd1;
        sr  <= sr_nxt;
        if (cnt == half - 7'd1) l_hold <= ext;
        if (cnt == flen - 7'd1) begin
          left_o  <= l_hold;
          right_o <= ext;
          valid_o <= 1'b1;
        end
      end
    end
  end

  // R7
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R7
  valid_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($past(cnt) == $past(flen) - 7'd1));

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |=> !frame_err_o);

  // R8
  err_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |-> !valid_o);

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= flen);

endmodule

// File: tb/stereo_rx_deser_tb.sv
module stereo_rx_deser_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OUT_W      = 28;
  localparam int HB         = 4;
  localparam int LAT        = 3;
  localparam int WDOG       = 150000;

  logic clk = 0, rst_n = 0, bclk = 0, wclk = 0, sd = 0, fmt = 0;
  logic [OUT_W-1:0] left_o, right_o;
  logic valid_o, frame_err_o;

  stereo_rx_deser #(.OUT_W(OUT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .wclk_in(wclk), .sdata_in(sd),
    .fmt24(fmt), .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
    .frame_err_o(frame_err_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  int v_due = -1, e_due = -1;
  logic [OUT_W-1:0] pend_l = '0, pend_r = '0, hold_l = '0, hold_r = '0;
  bit started = 0, mon_on = 0, done = 0;
  int bits_sent = 0, cur_flen = 64;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [OUT_W-1:0] expect_out(input bit f, input logic [31:0] v);
    logic signed [31:0] s;
    if (!f) return OUT_W'(v >> (32 - OUT_W));
    s = {{8{v[23]}}, v[23:0]};
    return s[OUT_W-1:0];
  endfunction

  always @(negedge clk) if (mon_on) begin
    check(valid_o === (cyc == v_due), {cur_req, " R7"}, "valid_o", 64'(valid_o), 64'(cyc == v_due));
    check(frame_err_o === (cyc == e_due), {cur_req, " R8"}, "frame_err_o", 64'(frame_err_o), 64'(cyc == e_due));
    if (cyc == v_due) begin
      hold_l = pend_l;
      hold_r = pend_r;
    end
    check(left_o === hold_l, {cur_req, " R7"}, "left_o", 64'(left_o), 64'(hold_l));
    check(right_o === hold_r, {cur_req, " R7"}, "right_o", 64'(right_o), 64'(hold_r));
  end

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) begin
      bclk = 1; sd = 1;
      wait_neg(HB);
      bclk = 0;
      if (started && bits_sent < cur_flen) bits_sent++;
      wait_neg(HB);
    end
  endtask

  task automatic send_frame(input bit f, input logic [31:0] lv, input logic [31:0] rv,
                            input int nbits, input int wpw, input bit flip);
    int slot = f ? 24 : 32;
    int flen = 2 * slot;
    fmt = f;
    for (int i = 0; i < nbits; i++) begin
      bclk = 1;
      if (i == 0) begin
        wclk = 1;
        if (started && bits_sent != cur_flen) e_due = cyc + LAT;
        started = 1; bits_sent = 0; cur_flen = flen;
      end
      if (i == wpw) wclk = 0;
      if (i < slot) sd = lv[slot-1-i];
      else if (i < flen) sd = rv[flen-1-i];
      else sd = 1;
      if (flip && i == 5) fmt = ~f;
      if (flip && i == flen - 3) fmt = f;
      wait_neg(HB);
      bclk = 0;
      if (bits_sent < cur_flen) bits_sent++;
      if (i == flen - 1) begin
        pend_l = expect_out(f, lv);
        pend_r = expect_out(f, rv);
        v_due  = cyc + LAT;
      end
      wait_neg(HB);
    end
    wclk = 0;
  endtask

  always @(posedge clk) if (!done && cyc == WDOG) begin
    checks++; errors++;
    $display("FAIL watchdog R7 actual=%0d expected=finished", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_neg(4);
    check(valid_o === 1'b0 && frame_err_o === 1'b0, "R1", "strobes in reset",
          {frame_err_o, valid_o}, 0);
    check(left_o === '0 && right_o === '0, "R1", "samples in reset",
          {left_o, right_o}, 0);
    rst_n = 1; mon_on = 1;
    cur_req = "R1 R10";
    idle_bits(10);
    cur_req = "R2 R3";
    send_frame(0, 32'h8123_4567, 32'h7ABC_DEF0, 64, 32, 0);
    cur_req = "R3 R6";
    send_frame(0, 32'hFFFF_FFF1, 32'h0000_0010, 64, 1, 0);
    send_frame(0, 32'h1357_9BDF, 32'hECA8_6420, 64, 63, 0);
    cur_req = "R4";
    send_frame(1, 32'h0080_0001, 32'h007F_FFFF, 48, 24, 0);
    cur_req = "R4 R6";
    send_frame(1, 32'h00C3_5A96, 32'h0012_3456, 48, 47, 0);
    cur_req = "R5";
    send_frame(1, 32'h00F0_0F0F, 32'h000A_5A5A, 48, 2, 1);
    send_frame(0, 32'hA5A5_5A5A, 32'h3C3C_C3C3, 64, 32, 1);
    cur_req = "R8";
    send_frame(0, 32'h1111_2222, 32'h3333_4444, 40, 16, 0);
    send_frame(0, 32'h5555_6666, 32'h7777_8888, 64, 32, 0);
    cur_req = "R9";
    send_frame(0, 32'h9999_AAAA, 32'hBBBB_CCCC, 67, 32, 0);
    send_frame(1, 32'h0080_0000, 32'h00FF_FFFF, 48, 24, 0);
    wait_neg(20);
    mon_on = 0; done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule